// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up 24 slow digital input lines before they reach input readback and change detection. Every raw line first crosses into the system clock domain through a two-flop synchronizer. A line whose filter is switched on then passes a new level to its output only once that level has held without interruption for a programmable stability interval. A line whose filter is off, or any line while the interval is zero, copies its synchronized input straight to the output.

The interval is a single 20-bit count shared by all lines. It is measured in ticks of a time base that a free-running prescaler derives from the system clock (one tick every `TICK_DIV` clocks, 200 ns per tick with the default setting at 50 MHz). Software rounds a requested time to the nearest tick. A byte-wide write port loads the interval, the per-line enable mask and two self-clearing clear strobes. One strobe zeroes the interval. The other drops every pending count and loads each output with its synchronized input.

Each line runs a small state machine. `LN_PASS` is the bypass state. It is left through `pass_to_stable` when the line is enabled and the interval is not zero, and it is entered from any state through `any_to_pass` when bypass applies. `LN_STABLE` means the output matches the input, and it moves to `LN_PENDING` through `stable_to_pending` when the two differ. `LN_PENDING` counts ticks. It takes the new level and goes back to `LN_STABLE` through `pending_accept` when the count reaches the interval. It returns to `LN_STABLE` through `pending_reject` when the input goes back to the output level, and through `pending_cleared` on a filter-state clear.

Top module: `glitch_filter_top`

## Requirements
- R1: After reset the interval is 0 and all enables are 0, so each output follows its raw input.
- R2: Register map, addressed by `reg_addr` and written when `reg_wr_en` is high. Offsets 0, 1 and 2 hold interval bits 7:0, 15:8 and 19:16, and bits 7:4 of the byte at offset 2 are ignored. Offsets 3, 4 and 5 hold the enable mask, where bit k at offset 3+j enables line 8j+k. Offset 6 is the clear register. Writes to other offsets have no effect.
- R3: A line with its enable bit at 0 shows a raw change on `filt_out` three clock edges after the raw input changes.
- R4: When the interval is 0, every line behaves as in R3 whatever its enable bit.
- R5: On an enabled line with interval N ≥ 2, a raw pulse that lasts no more than (N-1)·TICK_DIV-2 cycles never reaches the output.
- R6: On an enabled line with interval N ≥ 1, a new level held steady appears on the output no earlier than (N-1)·TICK_DIV+4 and no later than N·TICK_DIV+4 edges after the raw change.
- R7: The filtered output of an enabled line changes only on a prescaler tick, and ticks come every TICK_DIV clocks.
- R8: Writing offset 6 with bit 0 set zeroes the interval at that write edge, so all lines bypass from then on.
- R9: Writing offset 6 with bit 1 set discards all pending counts, and on the second edge after the write each output equals its synchronized input. The interval and the enables are kept.
- R10: Each line filters independently of the other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| raw_in | input | 24 | Asynchronous raw input lines |
| filt_out | output | 24 | Filtered input vector |

## Verification
A wrong lane state or a miscounted interval shows at the ports as a glitch that leaks through, or as a held level that arrives too early or too late. The bench brackets every level change between an earliest and a latest edge, so such an error is caught within one interval of the stimulus. A wrong enable or interval byte shows up as a line that bypasses when it should filter, or the reverse, and this is visible three edges after the next raw change. A clear strobe that is lost, or that touches the wrong state, changes the output level one edge after the strobe takes effect, or changes whether the next glitch is rejected.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;

    // Per-line filter state
    typedef enum logic [1:0] {
        LN_PASS    = 2'd0,
        LN_STABLE  = 2'd1,
        LN_PENDING = 2'd2
    } lane_state_t;

    // Bit positions inside the clear register
    localparam int unsigned CLR_IVL_BIT = 0;
    localparam int unsigned CLR_FLT_BIT = 1;

endpackage

// File: rtl/gf_regs.sv
module gf_regs #(
    parameter int unsigned LINES  = 24,
    parameter int unsigned IVL_W  = 20,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [IVL_W-1:0]  interval_o,
    output logic [LINES-1:0]  enable_o,
    output logic              flt_clear_o
);
    import glitch_filter_pkg::*;

    localparam int unsigned IVL_BYTES = (IVL_W + 7) / 8;
    localparam int unsigned EN_BYTES  = (LINES + 7) / 8;
    localparam int unsigned EN_BASE   = IVL_BYTES;
    localparam int unsigned CLR_OFS   = EN_BASE + EN_BYTES;
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_OFS);

    logic [IVL_W-1:0] ivl_q, ivl_d;
    logic [LINES-1:0] en_q, en_d;
    logic             flt_clr_q;
    logic             clr_hit;

    assign clr_hit = wr_en_i && (addr_i == CLR_ADDR);

    // Interval bits: byte i/8 loads bit i%8; the clear strobe wins
    for (genvar i = 0; i < IVL_W; i++) begin : g_ivl_bit
        always_comb begin
            if (clr_hit && wdata_i[CLR_IVL_BIT])
                ivl_d[i] = 1'b0;
            else if (wr_en_i && addr_i == ADDR_W'(i / 8))
                ivl_d[i] = wdata_i[i % 8];
            else
                ivl_d[i] = ivl_q[i];
        end
    end

    // Enable bits: line i lives in byte EN_BASE + i/8
    for (genvar i = 0; i < LINES; i++) begin : g_en_bit
        always_comb begin
            if (wr_en_i && addr_i == ADDR_W'(EN_BASE + i / 8))
                en_d[i] = wdata_i[i % 8];
            else
                en_d[i] = en_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q     <= '0;
            en_q      <= '0;
            flt_clr_q <= 1'b0;
        end else begin
            ivl_q     <= ivl_d;
            en_q      <= en_d;
            flt_clr_q <= clr_hit && wdata_i[CLR_FLT_BIT];
        end
    end

    assign interval_o  = ivl_q;
    assign enable_o    = en_q;
    assign flt_clear_o = flt_clr_q;

    // R8: an interval clear zeroes the interval at the write edge
    a_r8_clear_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == CLR_ADDR && wdata_i[CLR_IVL_BIT]) |=> (interval_o == '0));

    // R2: writes above the clear register change nothing
    a_r2_ignore_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i > CLR_ADDR) |=> ($stable(interval_o) && $stable(enable_o)));

    // R9: the filter-state strobe lasts exactly one cycle
    a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clear_o && !$past(clr_hit)) |-> 1'b0);

endmodule

// File: rtl/gf_tick.sv
module gf_tick #(
    parameter int unsigned TICK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    if (TICK_DIV <= 1) begin : g_every
        assign tick_o = 1'b1;
    end else begin : g_div
        localparam int unsigned CNT_W = $clog2(TICK_DIV);
        localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (restart_i || cnt_q == LAST)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end

        assign tick_o = (cnt_q == LAST);

        // R7: ticks never come on back-to-back edges
        a_r7_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
    end

endmodule

// File: rtl/gf_lane.sv
module gf_lane #(
    parameter int unsigned IVL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic             enable_i,
    input  logic [IVL_W-1:0] interval_i,
    input  logic             tick_i,
    input  logic             clear_i,
    output logic             filt_o
);
    import glitch_filter_pkg::*;

    logic             meta_q, sync_q;
    logic             out_q;
    logic [IVL_W-1:0] cnt_q;
    lane_state_t      state_q, state_d;
    logic             bypass;
    logic             differs;
    logic             reach;

    // Two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    assign bypass  = !enable_i || (interval_i == '0);
    assign differs = (sync_q != out_q);
    assign reach   = tick_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, interval_i});

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_PASS: begin
                if (!bypass) state_d = LN_STABLE;              // pass_to_stable
            end
            LN_STABLE: begin
                if (bypass)                 state_d = LN_PASS;     // any_to_pass
                else if (!clear_i && differs) state_d = LN_PENDING; // stable_to_pending
            end
            LN_PENDING: begin
                if (bypass)       state_d = LN_PASS;   // any_to_pass
                else if (clear_i) state_d = LN_STABLE; // pending_cleared
                else if (!differs) state_d = LN_STABLE; // pending_reject
                else if (reach)   state_d = LN_STABLE; // pending_accept
            end
            default: state_d = LN_PASS;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_PASS;
        else        state_q <= state_d;
    end

    // Output and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (bypass || clear_i) begin
            out_q <= sync_q;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                LN_PENDING: begin
                    if (!differs) begin
                        cnt_q <= '0;
                    end else if (reach) begin
                        out_q <= sync_q;
                        cnt_q <= '0;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign filt_o = out_q;

    // R3 / R4: bypass copies the synchronized input one edge later
    a_r3_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || interval_i == '0) |=> (filt_o == $past(sync_q)));

    // R9: a filter-state clear loads the synchronized input
    a_r9_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (filt_o == $past(sync_q)));

    // R7: while filtering, the output moves only on a tick
    a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && interval_i != '0 && !clear_i && !tick_i) |=> $stable(filt_o));

    // R5: a settled line holds its output until a mismatch is seen
    a_r5_stable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_STABLE && enable_i && interval_i != '0 && !clear_i) |=> $stable(filt_o));

endmodule

// File: rtl/glitch_filter_top.sv
module glitch_filter_top #(
    parameter int unsigned LINES    = 24,
    parameter int unsigned IVL_W    = 20,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [LINES-1:0]  raw_in,
    output logic [LINES-1:0]  filt_out
);
    logic [IVL_W-1:0] interval;
    logic [LINES-1:0] enable;
    logic             flt_clear;
    logic             tick;

    gf_regs #(
        .LINES  (LINES),
        .IVL_W  (IVL_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr_en),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .interval_o  (interval),
        .enable_o    (enable),
        .flt_clear_o (flt_clear)
    );

    gf_tick #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (flt_clear),
        .tick_o    (tick)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_lane
        gf_lane #(
            .IVL_W (IVL_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (raw_in[l]),
            .enable_i   (enable[l]),
            .interval_i (interval),
            .tick_i     (tick),
            .clear_i    (flt_clear),
            .filt_o     (filt_out[l])
        );
    end

endmodule

// File: tb/glitch_filter_top_tb_top.sv
module glitch_filter_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 10;   // TICK_DIV
    localparam int LINES      = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [LINES-1:0]  raw_in = '0;
    logic [LINES-1:0]  filt_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    glitch_filter_top #(.TICK_DIV(P)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_in    (raw_in),
        .filt_out  (filt_out)
    );

    function automatic logic [LINES-1:0] mix(input logic [LINES-1:0] mask,
                                             input logic [LINES-1:0] slow,
                                             input logic [LINES-1:0] fast);
        return (slow & mask) | (fast & ~mask);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [LINES-1:0] got,
                         input logic [LINES-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        step(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_interval(input int n);
        wr(4'd0, 8'(n));
        wr(4'd1, 8'(n >> 8));
        wr(4'd2, 8'(n >> 16) | 8'hF0);   // upper nibble must be ignored
    endtask

    task automatic set_mask(input logic [LINES-1:0] m);
        wr(4'd3, m[7:0]);
        wr(4'd4, m[15:8]);
        wr(4'd5, m[23:16]);
    endtask

    task automatic settle(input int n);
        step(n * P + 6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LINES-1:0] cur, v, g, m;
        int n, w;
        void'($urandom(32'd4711));

        step(3);
        rst_n = 1'b1;
        step(2);

        // R1: reset state follows raw input
        check("R1 reset output", filt_out, 24'h000000);
        raw_in = 24'hA5C3F0;
        step(3);
        check("R1 pass after reset", filt_out, 24'hA5C3F0);

        // R2/R6: interval 5 with ignored top nibble, all lines enabled
        set_interval(5);
        set_mask(24'hFFFFFF);
        settle(1);
        raw_in = 24'h5A3C0F;
        step((5 - 1) * P + 2);
        check("R6 not before window", filt_out, 24'hA5C3F0);
        step(P + 2);
        check("R2 R6 accepted within window", filt_out, 24'h5A3C0F);

        // R5: short pulse rejected
        raw_in = 24'hFFFFFF;
        step((5 - 1) * P - 2);
        raw_in = 24'h5A3C0F;
        step(5 * P + 6);
        check("R5 glitch rejected", filt_out, 24'h5A3C0F);

        // R2: write to an unused offset changes nothing
        wr(4'd9, 8'h03);
        raw_in = 24'h000000;
        step(3);
        check("R2 unused offset keeps filtering", filt_out, 24'h5A3C0F);
        settle(5);
        check("R6 held level taken", filt_out, 24'h000000);

        // R9: clear filter state during a pending change
        raw_in = 24'h00FF00;
        step(12);
        check("R9 pending before clear", filt_out, 24'h000000);
        wr(4'd6, 8'h02);
        step(1);
        check("R9 clear loads input", filt_out, 24'h00FF00);
        raw_in = 24'h000000;
        step((5 - 1) * P - 2);
        raw_in = 24'h00FF00;
        step(5 * P + 6);
        check("R9 interval kept after clear", filt_out, 24'h00FF00);

        // R8/R4: interval clear turns every line into a bypass
        wr(4'd6, 8'h01);
        raw_in = 24'h123456;
        step(3);
        check("R8 R4 bypass after interval clear", filt_out, 24'h123456);

        // R7: interval 1 takes effect within one tick period
        set_interval(1);
        settle(1);
        raw_in = 24'h654321;
        step(3);
        check("R7 not before tick", filt_out, 24'h123456);
        step(P + 1);
        check("R7 one tick accepted", filt_out, 24'h654321);

        // R3/R10: random masks and patterns
        cur = 24'h654321;
        for (int r = 0; r < 24; r++) begin
            n = 2 + int'($urandom_range(0, 2));
            m = LINES'($urandom);
            v = LINES'($urandom);
            g = LINES'($urandom) | 24'h000001;
            w = (n - 1) * P - 2;
            set_interval(n);
            set_mask(m);
            settle(n);
            check("R10 settle", filt_out, cur);
            raw_in = v;
            step(3);
            check("R3 R10 bypass lines move first", filt_out, mix(m, cur, v));
            step(n * P + 2);
            check("R6 R10 held level", filt_out, v);
            raw_in = v ^ g;
            step(3);
            check("R3 R5 glitch only on bypass lines", filt_out, mix(m, v, v ^ g));
            step(w - 3);
            raw_in = v;
            step(n * P + 6);
            check("R5 R10 after glitch", filt_out, v);
            cur = v;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule